// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits between the serial bus engine of a small non-volatile memory and its storage array. The bus engine hands it one accepted data byte at a time, with the byte's full address. The block gathers these bytes into a buffer of one page (16 slots by default). The first byte of a transfer fixes the page number and the starting slot. Every later byte goes to the next slot, and the slot number wraps inside the page.

A STOP strobe ends the transfer. If STOP arrives with at least one byte held and write-protect low, the block runs one self-timed write cycle of a programmable number of clocks. During that cycle it raises a busy flag, which the bus engine uses to withhold acknowledges. In the first clocks of the cycle it writes each held slot to the array through a simple write port. When the count expires it drops busy and gives a one-clock done pulse.

An abort strobe discards the transfer. The bus engine raises it for a repeated START or a protocol error before STOP. Write-protect blocks both the collection of bytes and the commit.

Top module: `pgwr_sequencer`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `arr_we_o` are all 0.
- R2: The first accepted byte of a transfer takes its page number from address bits [9:4] and its slot from bits [3:0]. Each later byte of the same transfer goes to the previous slot plus one. The address presented with a later byte is ignored, and every array write of the commit carries the first byte's page in bits [9:4].
- R3: The slot number wraps from 15 to 0. A byte that lands on a slot already filled in the same transfer replaces the earlier byte, and a commit never writes more than 16 bytes.
- R4: A one-clock `stop_i` pulse with at least one byte held, `wp_i` low and the block idle raises `busy_o` at the next clock edge. `busy_o` then stays high for exactly CYCLE_CLKS clocks.
- R5: During the cycle, the array port writes only the slots that were filled. Writes go one per clock in ascending slot order, in the first 16 clocks of the cycle, with address {page, slot} and the stored byte. Slots that were not filled are not written.
- R6: `done_o` is high for exactly one clock, the first clock with `busy_o` low after a cycle. The buffer is then empty, and the next byte starts a new transfer at its own address.
- R7: Bytes presented while `wp_i` is high are not stored. A `stop_i` while `wp_i` is high starts no cycle and discards any held bytes.
- R8: An `abort_i` pulse while idle discards all held bytes and starts no cycle. The next byte starts a new transfer at its own address.
- R9: While `busy_o` is high, bytes, `stop_i` and `abort_i` are ignored. The cycle length and the data written are unchanged, and bytes offered during the cycle are never stored.
- R10: A `stop_i` with no byte held starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld_i | input | 1 | One-clock strobe: a data byte is offered |
| byte_addr_i | input | 10 | Full array address of the offered byte |
| byte_data_i | input | 8 | Offered data byte |
| stop_i | input | 1 | One-clock strobe: STOP seen on the bus |
| abort_i | input | 1 | One-clock strobe: START or protocol error before STOP |
| wp_i | input | 1 | Write-protect level |
| busy_o | output | 1 | High for the whole self-timed write cycle |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | 10 | Array write address |
| arr_data_o | output | 8 | Array write data |
| done_o | output | 1 | One-clock pulse when the write cycle ends |

## Verification
The commit is driven with five byte patterns. A lone byte shows the single-byte case. A short run that starts at slot 14, with later addresses set to junk, separates a design that follows its own pointer from one that trusts each address and shows the wrap. An 18-byte run separates overwrite-on-wrap from appending or dropping. A run offered during a busy cycle separates true blocking from late capture. Protect, abort and empty-STOP cases are each followed by a clean transfer. That transfer shows, at the array port, whether any earlier byte or the old page leaked through.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  // Slot index after `slot`, wrapping inside a page of `slots` entries.
  function automatic int unsigned next_slot(input int unsigned slot,
                                            input int unsigned slots);
    return (slot + 1 >= slots) ? 0 : slot + 1;
  endfunction

  // True on the final clock of a cycle of `len` clocks (count starts at 0).
  function automatic logic cycle_last(input int unsigned count,
                                      input int unsigned len);
    return (count + 1 == len);
  endfunction

  // Commit scan is active on the first `slots` clocks of the cycle.
  function automatic logic in_scan(input int unsigned count,
                                   input int unsigned slots);
    return (count < slots);
  endfunction

endpackage

// File: rtl/pgwr_slot_buffer.sv
module pgwr_slot_buffer #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOTS  = 16,
  localparam int unsigned OFS_W  = $clog2(SLOTS),
  localparam int unsigned PAGE_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put_i,
  input  logic [ADDR_W-1:0] put_addr_i,
  input  logic [DATA_W-1:0] put_data_i,
  input  logic              clear_i,
  input  logic [OFS_W-1:0]  rd_slot_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              any_valid_o
);

  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SLOTS-1:0]  valid_q;
  logic [OFS_W-1:0]  ptr_q;
  logic              open_q;
  logic [PAGE_W-1:0] page_q;

  // Slot the current byte lands in: its own address opens a transfer,
  // after that the running pointer decides.
  logic [OFS_W-1:0]  cur_slot;
  logic [OFS_W-1:0]  nxt_slot;

  assign cur_slot = open_q ? ptr_q : put_addr_i[OFS_W-1:0];
  assign nxt_slot = OFS_W'(pgwr_pkg::next_slot(32'(cur_slot), SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ptr_q  <= '0;
      page_q <= '0;
    end else if (clear_i) begin
      open_q <= 1'b0;
    end else if (put_i) begin
      open_q <= 1'b1;
      ptr_q  <= nxt_slot;
      if (!open_q) page_q <= put_addr_i[ADDR_W-1:OFS_W];
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
        data_q[s]  <= '0;
      end else if (clear_i) begin
        valid_q[s] <= 1'b0;
      end else if (put_i && cur_slot == OFS_W'(s)) begin
        valid_q[s] <= 1'b1;
        data_q[s]  <= put_data_i;
      end
    end
  end

  assign rd_data_o   = data_q[rd_slot_i];
  assign rd_valid_o  = valid_q[rd_slot_i];
  assign page_o      = page_q;
  assign any_valid_o = |valid_q;

endmodule

// File: rtl/pgwr_cycle_timer.sv
module pgwr_cycle_timer #(
  parameter int unsigned CYCLE_CLKS = 500,
  localparam int unsigned CNT_W = $clog2(CYCLE_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] count_o,
  output logic             end_o,
  output logic             done_o
);

  logic             busy_q;
  logic [CNT_W-1:0] count_q;
  logic             done_q;

  assign end_o = busy_q && pgwr_pkg::cycle_last(32'(count_q), CYCLE_CLKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          count_q <= '0;
        end
      end else if (end_o) begin
        busy_q  <= 1'b0;
        count_q <= '0;
        done_q  <= 1'b1;
      end else begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign count_o = count_q;
  assign done_o  = done_q;

endmodule

// File: rtl/pgwr_commit_scan.sv
module pgwr_commit_scan #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SLOTS      = 16,
  parameter int unsigned CYCLE_CLKS = 500,
  localparam int unsigned OFS_W  = $clog2(SLOTS),
  localparam int unsigned PAGE_W = ADDR_W - OFS_W,
  localparam int unsigned CNT_W  = $clog2(CYCLE_CLKS + 1)
) (
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [DATA_W-1:0] slot_data_i,
  input  logic              slot_valid_i,
  output logic [OFS_W-1:0]  slot_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  // CYCLE_CLKS must be at least SLOTS so the scan fits inside the cycle.
  logic scan_on;

  assign scan_on = busy_i && pgwr_pkg::in_scan(32'(count_i), SLOTS);
  assign slot_o  = OFS_W'(count_i);
  assign we_o    = scan_on && slot_valid_i;
  assign addr_o  = {page_i, slot_o};
  assign data_o  = slot_data_i;

endmodule

// File: rtl/pgwr_sequencer.sv
module pgwr_sequencer #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned CYCLE_CLKS = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stop_i,
  input  logic              abort_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              done_o
);

  localparam int unsigned OFS_W  = $clog2(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;
  localparam int unsigned CNT_W  = $clog2(CYCLE_CLKS + 1);

  // Named internal events
  logic              busy;
  logic              accept_byte;
  logic              commit_start;
  logic              drop_xfer;
  logic              cyc_end;
  logic              any_valid;
  logic [CNT_W-1:0]  cyc_count;
  logic [OFS_W-1:0]  scan_slot;
  logic [DATA_W-1:0] slot_data;
  logic              slot_valid;
  logic [PAGE_W-1:0] page;

  assign accept_byte  = byte_vld_i && !busy && !wp_i && !stop_i && !abort_i;
  assign commit_start = stop_i && !abort_i && !busy && !wp_i && any_valid;
  assign drop_xfer    = !busy && (abort_i || (stop_i && !commit_start));

  pgwr_slot_buffer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SLOTS  (PAGE_BYTES)
  ) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .put_i       (accept_byte),
    .put_addr_i  (byte_addr_i),
    .put_data_i  (byte_data_i),
    .clear_i     (drop_xfer || cyc_end),
    .rd_slot_i   (scan_slot),
    .rd_data_o   (slot_data),
    .rd_valid_o  (slot_valid),
    .page_o      (page),
    .any_valid_o (any_valid)
  );

  pgwr_cycle_timer #(
    .CYCLE_CLKS (CYCLE_CLKS)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (commit_start),
    .busy_o  (busy),
    .count_o (cyc_count),
    .end_o   (cyc_end),
    .done_o  (done_o)
  );

  pgwr_commit_scan #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SLOTS      (PAGE_BYTES),
    .CYCLE_CLKS (CYCLE_CLKS)
  ) u_scan (
    .busy_i       (busy),
    .count_i      (cyc_count),
    .page_i       (page),
    .slot_data_i  (slot_data),
    .slot_valid_i (slot_valid),
    .slot_o       (scan_slot),
    .we_o         (arr_we_o),
    .addr_o       (arr_addr_o),
    .data_o       (arr_data_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/pgwr_sequencer_chk.sv
module pgwr_sequencer_chk #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned CYCLE_CLKS = 500,
  localparam int unsigned OFS_W = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              wp,
  input logic              abort
);

  // Length of the current busy run, counted in the checker.
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= '0;
  end

  p_we_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> arr_addr[OFS_W-1:0] > $past(arr_addr[OFS_W-1:0]));

  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> arr_addr[ADDR_W-1:OFS_W] == $past(arr_addr[ADDR_W-1:OFS_W]));

  p_cycle_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == 32'(CYCLE_CLKS));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_len < 32'(CYCLE_CLKS - 1)) |=> busy);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wp) |=> !busy);

  p_abort_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && abort) |=> !busy);

endmodule

bind pgwr_sequencer pgwr_sequencer_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .CYCLE_CLKS (CYCLE_CLKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done_o),
  .arr_we   (arr_we_o),
  .arr_addr (arr_addr_o),
  .wp       (wp_i),
  .abort    (abort_i)
);

// File: tb/pgwr_sequencer_test.sv
module pgwr_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 24;

  logic       clk;
  logic       rst_n;
  logic       byte_vld;
  logic [9:0] byte_addr;
  logic [7:0] byte_data;
  logic       stop;
  logic       abort;
  logic       wp;
  logic       busy;
  logic       arr_we;
  logic [9:0] arr_addr;
  logic [7:0] arr_data;
  logic       done;

  pgwr_sequencer #(.CYCLE_CLKS(CYC)) uut (
    .clk(clk), .rst_n(rst_n),
    .byte_vld_i(byte_vld), .byte_addr_i(byte_addr), .byte_data_i(byte_data),
    .stop_i(stop), .abort_i(abort), .wp_i(wp),
    .busy_o(busy), .arr_we_o(arr_we), .arr_addr_o(arr_addr),
    .arr_data_o(arr_data), .done_o(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // Bench model of the page buffer, written from the requirements.
  logic [7:0] m_data [16];
  bit         m_valid [16];
  logic [5:0] m_page;
  int         m_ptr;
  bit         m_open;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_open = 0;
    for (int s = 0; s < 16; s++) m_valid[s] = 0;
  endtask

  task automatic put_byte(input logic [9:0] a, input logic [7:0] d, input bit kept);
    @(negedge clk);
    byte_vld = 1; byte_addr = a; byte_data = d;
    @(negedge clk);
    byte_vld = 0; byte_addr = '0; byte_data = '0;
    if (kept) begin
      if (!m_open) begin m_page = a[9:4]; m_ptr = int'(a[3:0]); m_open = 1; end
      m_data[m_ptr]  = d;
      m_valid[m_ptr] = 1;
      m_ptr = (m_ptr + 1) % 16;
    end
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  // STOP, then follow the whole cycle; optionally poke inputs while busy.
  task automatic expect_commit(input string req, input bit poke);
    logic [9:0] ea [16];
    logic [7:0] ed [16];
    logic [9:0] ga [32];
    logic [7:0] gd [32];
    int ew = 0, nw = 0, nb = 0;
    for (int s = 0; s < 16; s++)
      if (m_valid[s]) begin ea[ew] = {m_page, 4'(s)}; ed[ew] = m_data[s]; ew++; end
    pulse_stop();
    for (int g = 0; g < 1000 && busy; g++) begin
      if (arr_we) begin
        if (nw < 32) begin ga[nw] = arr_addr; gd[nw] = arr_data; end
        nw++;
      end
      nb++;
      if (poke) begin
        byte_vld  = (nb >= 3 && nb <= 6);
        byte_addr = 10'h3F0 + 10'(nb);
        byte_data = 8'hE0 + 8'(nb);
        stop      = (nb == 9);
        abort     = (nb == 12);
      end
      @(negedge clk);
    end
    byte_vld = 0; stop = 0; abort = 0;
    chk(nb == CYC, "R4", {req, " busy length"}, nb, CYC);
    chk(done == 1'b1, "R6", {req, " done at busy fall"}, int'(done), 1);
    chk(nw == ew, "R5", {req, " write count"}, nw, ew);
    for (int i = 0; i < ew && i < nw; i++) begin
      chk(ga[i] == ea[i], req, "write address", int'(ga[i]), int'(ea[i]));
      chk(gd[i] == ed[i], req, "write data", int'(gd[i]), int'(ed[i]));
    end
    @(negedge clk);
    chk(done == 1'b0, "R6", {req, " done one clock"}, int'(done), 0);
    model_clear();
  endtask

  task automatic expect_no_commit(input string req);
    int bad = 0;
    pulse_stop();
    for (int i = 0; i < 6; i++) begin
      if (busy || arr_we || done) bad++;
      @(negedge clk);
    end
    chk(bad == 0, req, "idle after STOP (busy/we/done cycles)", bad, 0);
    model_clear();
  endtask

  task automatic t_reset();
    chk(busy == 0 && arr_we == 0 && done == 0, "R1", "outputs after reset",
        int'({busy, arr_we, done}), 0);
  endtask

  task automatic t_single();
    put_byte(10'h2A5, 8'h3C, 1);
    expect_commit("R5", 0);
  endtask

  task automatic t_start_near_top();
    put_byte(10'h1DE, 8'h11, 1);
    put_byte(10'h000, 8'h22, 1);
    put_byte(10'h3FF, 8'h33, 1);
    put_byte(10'h155, 8'h44, 1);
    put_byte(10'h2AA, 8'h55, 1);
    expect_commit("R2", 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 18; i++) put_byte(10'h0C3, 8'(8'h80 + i), 1);
    chk(m_data[3] == 8'h90, "R3", "model overwrite of slot 3", int'(m_data[3]), 'h90);
    expect_commit("R3", 0);
  endtask

  task automatic t_protect();
    wp = 1;
    put_byte(10'h040, 8'hA1, 0);
    put_byte(10'h041, 8'hA2, 0);
    expect_no_commit("R7");
    wp = 0;
    put_byte(10'h050, 8'hB1, 1);
    wp = 1;
    expect_no_commit("R7");
    wp = 0;
    expect_no_commit("R7");
    put_byte(10'h067, 8'hC7, 1);
    expect_commit("R7", 0);
  endtask

  task automatic t_abort();
    put_byte(10'h120, 8'h01, 1);
    put_byte(10'h000, 8'h02, 1);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    model_clear();
    expect_no_commit("R8");
    put_byte(10'h23B, 8'h5A, 1);
    expect_commit("R8", 0);
  endtask

  task automatic t_busy_ignored();
    put_byte(10'h304, 8'h77, 1);
    put_byte(10'h000, 8'h78, 1);
    expect_commit("R9", 1);
    expect_no_commit("R9");
  endtask

  task automatic t_empty_stop();
    expect_no_commit("R10");
  endtask

  task automatic t_next_page();
    put_byte(10'h3F9, 8'hD0, 1);
    expect_commit("R6", 0);
    put_byte(10'h012, 8'hD1, 1);
    put_byte(10'h3FF, 8'hD2, 1);
    expect_commit("R6", 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; byte_vld = 0; byte_addr = '0; byte_data = '0;
    stop = 0; abort = 0; wp = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_start_near_top();
    t_overflow();
    t_protect();
    t_abort();
    t_busy_ignored();
    t_empty_stop();
    t_next_page();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule